// File: doc/BRIEF.md
# Message Signaled Interrupt Generator

This block sits on the device side of a peripheral. It holds the three configuration registers that describe interrupt messages: a control word, a destination address and a data word. It turns internal event pulses into single posted memory writes. No interrupt wires and no acknowledge exchange are involved. Each message carries the destination, the delivery mode and the vector in its address and data. When software grants more than one message, the low bits of the vector identify the event that caused it.

Software programs the registers through a simple word-wide port. Event pulses on any of up to 32 inputs are held as pending. Once the message enable is set, pending events go out one at a time on a valid/ready write-request port, lowest index first. Each pending bit is dropped only when its write is accepted.

Top module: `msi_sender`

## Requirements
- R1: After reset the control word reads the capable-count code in bits 3:1 and the 64-bit flag (1 when the upper address word exists) in bit 7, with all other bits 0. The low address word reads 0xFEE00000, the data word reads 0 and wrValid is low.
- R2: In the control word (register index 0), bit 0 is the message enable, bits 6:4 hold the granted-count code, bits 3:1 and 7 ignore writes, and bits 15:8 and above read 0.
- R3: A granted-count code written above the capable code, including the reserved codes 110 and 111, is stored as the capable code. Count codes mean 2^code messages (000 = 1 up to 101 = 32).
- R4: The low address word (index 1) reads 0xFEE in bits 31:20, a writable destination ID in bits 19:12, the redirection hint in bit 3 and the destination mode in bit 2, with every other bit 0. The upper address word (index 2) is fully writable when 64-bit addressing is present.
- R5: The data word (index 3) keeps bits 7:0 (vector), 10:8 (delivery mode), 14 (level) and 15 (trigger mode) and reads 0 in all other bits.
- R6: While the enable bit is 0 no write starts, and events stay pending. They are sent once the enable bit is set.
- R7: Each write carries the upper address word in bits 63:32, the low address word in bits 31:0, and the data word with its low vector bits replaced as in R8.
- R8: With granted code n, the write for event k carries k mod 2^n in data bits n-1:0. All other vector bits come from the register.
- R9: Pending events are sent lowest index first. Each event produces exactly one write, and its pending bit clears when that write is accepted.
- R10: While wrValid is high and wrReady is low, wrValid stays high and wrAddr and wrData do not change.
- R11: An event that arrives in the cycle its own pending write is accepted stays pending and produces a further write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regAddr | input | 2 | Register index: 0 control, 1 address low, 2 address high, 3 data |
| regWe | input | 1 | Register write strobe |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Register read data for regAddr (combinational) |
| evtIn | input | NUM_EVENTS | Event pulses, one per interrupt source |
| wrValid | output | 1 | Write request valid |
| wrReady | input | 1 | Write request accepted when high with wrValid |
| wrAddr | output | 64 | Write address |
| wrData | output | 32 | Write data |

## Verification
The bench builds the block with 32 event inputs, a capable code of 3 (eight messages) and the upper address word present. A capable code below the top code makes clamping of both legal-but-too-large codes and reserved codes visible, and lets event indices above 7 show the modulo wrap of the low vector bits. A vector with its low bits set shows that those bits are replaced and not ORed. Held-off acceptance combined with a repeated event on the acceptance cycle covers the handshake hold and the re-arm of a pending bit.

// File: rtl/msi_gen_pkg.sv
package msi_gen_pkg;
  localparam int unsigned IDX_W = 5;

  typedef struct packed {
    logic              launch;
    logic              accept;
    logic [IDX_W-1:0]  idx;
  } ctlStrobes_t;

  localparam logic [1:0] REG_CTRL = 2'd0;
  localparam logic [1:0] REG_ALO  = 2'd1;
  localparam logic [1:0] REG_AHI  = 2'd2;
  localparam logic [1:0] REG_DATA = 2'd3;

  localparam logic [11:0] ADDR_TOP = 12'hFEE;
endpackage

// File: rtl/msi_datapath.sv
module msi_datapath
  import msi_gen_pkg::*;
#(
  parameter int unsigned NUM_EVENTS = 32,
  parameter int unsigned CAP_CODE   = 5,
  parameter bit          ADDR64     = 1'b1
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [1:0]            regAddr,
  input  logic                  regWe,
  input  logic [31:0]           regWrData,
  output logic [31:0]           regRdData,
  input  logic [NUM_EVENTS-1:0] evtIn,
  input  ctlStrobes_t           strobes,
  output logic [NUM_EVENTS-1:0] pending,
  output logic                  msgEn,
  output logic [63:0]           wrAddr,
  output logic [31:0]           wrData
);
  localparam logic [2:0] CAP = 3'(CAP_CODE);

  logic [2:0]  grantCode;
  logic [7:0]  destId;
  logic        redirHint, destMode;
  logic [31:0] addrHi;
  logic [7:0]  vector;
  logic [2:0]  delivMode;
  logic        lvl, trig;

  function automatic logic [2:0] clampGrant(input logic [2:0] code);
    return (code > CAP) ? CAP : code;
  endfunction

  wire wrCtrl = regWe && (regAddr == REG_CTRL);
  wire wrAlo  = regWe && (regAddr == REG_ALO);
  wire wrAhi  = regWe && (regAddr == REG_AHI);
  wire wrDat  = regWe && (regAddr == REG_DATA);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      msgEn     <= 1'b0;
      grantCode <= 3'd0;
      destId    <= 8'd0;
      redirHint <= 1'b0;
      destMode  <= 1'b0;
      vector    <= 8'd0;
      delivMode <= 3'd0;
      lvl       <= 1'b0;
      trig      <= 1'b0;
    end else begin
      if (wrCtrl) begin
        msgEn     <= regWrData[0];
        grantCode <= clampGrant(regWrData[6:4]);
      end
      if (wrAlo) begin
        destId    <= regWrData[19:12];
        redirHint <= regWrData[3];
        destMode  <= regWrData[2];
      end
      if (wrDat) begin
        vector    <= regWrData[7:0];
        delivMode <= regWrData[10:8];
        lvl       <= regWrData[14];
        trig      <= regWrData[15];
      end
    end
  end

  generate
    if (ADDR64) begin : g_hi
      always_ff @(posedge clk) begin
        if (!rstN)      addrHi <= 32'd0;
        else if (wrAhi) addrHi <= regWrData;
      end
    end else begin : g_nohi
      assign addrHi = 32'd0;
    end
  endgenerate

  wire [31:0] addrLoWord = {ADDR_TOP, destId, 8'h00, redirHint, destMode, 2'b00};
  wire [31:0] dataWord   = {16'h0000, trig, lvl, 3'b000, delivMode, vector};

  always_comb begin
    unique case (regAddr)
      REG_CTRL: regRdData = {16'h0000, 8'h00, ADDR64, grantCode, CAP, msgEn};
      REG_ALO:  regRdData = addrLoWord;
      REG_AHI:  regRdData = addrHi;
      default:  regRdData = dataWord;
    endcase
  end

  // Low vector bits replaced by the event index, width set by the grant.
  logic [7:0] lowMask, vecOut;
  always_comb begin
    lowMask = ~(8'hFF << grantCode);
    vecOut  = (vector & ~lowMask) | ({3'b000, strobes.idx} & lowMask);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrAddr <= 64'd0;
      wrData <= 32'd0;
    end else if (strobes.launch) begin
      wrAddr <= {addrHi, addrLoWord};
      wrData <= {dataWord[31:8], vecOut};
    end
  end

  genvar b;
  generate
    for (b = 0; b < NUM_EVENTS; b++) begin : g_pend
      wire clrBit = strobes.accept && (strobes.idx == IDX_W'(b));
      always_ff @(posedge clk) begin
        if (!rstN)                pending[b] <= 1'b0;
        else if (evtIn[b])        pending[b] <= 1'b1;
        else if (clrBit)          pending[b] <= 1'b0;
      end
    end
  endgenerate
endmodule

// File: rtl/msi_control.sv
module msi_control
  import msi_gen_pkg::*;
#(
  parameter int unsigned NUM_EVENTS = 32
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  msgEn,
  input  logic [NUM_EVENTS-1:0] pending,
  input  logic                  wrReady,
  output logic                  wrValid,
  output ctlStrobes_t           strobes
);
  logic             busy;
  logic [IDX_W-1:0] idxReg, pickIdx;

  always_comb begin
    pickIdx = '0;
    for (int i = NUM_EVENTS - 1; i >= 0; i--) begin
      if (pending[i]) pickIdx = IDX_W'(i);
    end
  end

  always_comb begin
    strobes.launch = !busy && msgEn && (|pending);
    strobes.accept = busy && wrReady;
    strobes.idx    = busy ? idxReg : pickIdx;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy   <= 1'b0;
      idxReg <= '0;
    end else if (strobes.launch) begin
      busy   <= 1'b1;
      idxReg <= pickIdx;
    end else if (strobes.accept) begin
      busy   <= 1'b0;
    end
  end

  assign wrValid = busy;
endmodule

// File: rtl/msi_sender.sv
module msi_sender
  import msi_gen_pkg::*;
#(
  parameter int unsigned NUM_EVENTS = 32,
  parameter int unsigned CAP_CODE   = 5,
  parameter bit          ADDR64     = 1'b1
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [1:0]            regAddr,
  input  logic                  regWe,
  input  logic [31:0]           regWrData,
  output logic [31:0]           regRdData,
  input  logic [NUM_EVENTS-1:0] evtIn,
  output logic                  wrValid,
  input  logic                  wrReady,
  output logic [63:0]           wrAddr,
  output logic [31:0]           wrData
);
  ctlStrobes_t           strobes;
  logic [NUM_EVENTS-1:0] pending;
  logic                  msgEn;

  msi_datapath #(
    .NUM_EVENTS(NUM_EVENTS), .CAP_CODE(CAP_CODE), .ADDR64(ADDR64)
  ) u_dp (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWe(regWe),
    .regWrData(regWrData), .regRdData(regRdData), .evtIn(evtIn),
    .strobes(strobes), .pending(pending), .msgEn(msgEn),
    .wrAddr(wrAddr), .wrData(wrData)
  );

  msi_control #(.NUM_EVENTS(NUM_EVENTS)) u_ctl (
    .clk(clk), .rstN(rstN), .msgEn(msgEn), .pending(pending),
    .wrReady(wrReady), .wrValid(wrValid), .strobes(strobes)
  );
endmodule

// File: rtl/msi_sender_checker.sv
module msi_sender_checker #(
  parameter int unsigned CAP_CODE = 5
) (
  input logic        clk,
  input logic        rstN,
  input logic [1:0]  regAddr,
  input logic [31:0] regRdData,
  input logic        msgEn,
  input logic        wrValid,
  input logic        wrReady,
  input logic [63:0] wrAddr,
  input logic [31:0] wrData
);
  // R10
  valid_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    wrValid && !wrReady |=> wrValid && $stable(wrAddr) && $stable(wrData));

  // R6
  start_enabled_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(wrValid) |-> $past(msgEn));

  // R4
  addr_fixed_chk: assert property (@(posedge clk) disable iff (!rstN)
    wrValid |-> (wrAddr[31:20] == 12'hFEE) && (wrAddr[1:0] == 2'b00) && (wrAddr[11:4] == 8'h00));

  // R5
  data_reserved_chk: assert property (@(posedge clk) disable iff (!rstN)
    wrValid |-> (wrData[31:16] == 16'h0) && (wrData[13:11] == 3'b000));

  // R3
  grant_clamp_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regAddr == 2'd0) |-> (regRdData[6:4] <= 3'(CAP_CODE)));
endmodule

bind msi_sender msi_sender_checker #(.CAP_CODE(CAP_CODE)) u_chk (
  .clk(clk), .rstN(rstN), .regAddr(regAddr), .regRdData(regRdData),
  .msgEn(msgEn), .wrValid(wrValid), .wrReady(wrReady),
  .wrAddr(wrAddr), .wrData(wrData)
);

// File: tb/msi_sender_test.sv
`timescale 1ns/1ps
module msi_sender_test;
  localparam int unsigned NEV = 32;

  logic            clk = 1'b0;
  logic            rstN = 1'b0;
  logic [1:0]      regAddr = 2'd0;
  logic            regWe = 1'b0;
  logic [31:0]     regWrData = 32'd0;
  logic [31:0]     regRdData;
  logic [NEV-1:0]  evtIn = '0;
  logic            wrValid;
  logic            wrReady = 1'b1;
  logic [63:0]     wrAddr;
  logic [31:0]     wrData;

  msi_sender #(.NUM_EVENTS(NEV), .CAP_CODE(3), .ADDR64(1'b1)) uut (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWe(regWe),
    .regWrData(regWrData), .regRdData(regRdData), .evtIn(evtIn),
    .wrValid(wrValid), .wrReady(wrReady), .wrAddr(wrAddr), .wrData(wrData)
  );

  always #5 clk = ~clk;

  int checks = 0;
  int errors = 0;
  int nGot = 0;
  logic [63:0] gotAddr [64];
  logic [31:0] gotData [64];

  // Record every accepted write
  always begin
    @(negedge clk); #1;
    if (rstN && wrValid && wrReady && nGot < 64) begin
      gotAddr[nGot] = wrAddr;
      gotData[nGot] = wrData;
      nGot++;
    end
  end

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic regWrite(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    regAddr = a; regWe = 1'b1; regWrData = d;
    @(negedge clk);
    regWe = 1'b0;
  endtask

  task automatic regRead(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    regAddr = a; #1;
    d = regRdData;
  endtask

  task automatic pulse(input int k);
    @(negedge clk);
    evtIn = '0; evtIn[k] = 1'b1;
    @(negedge clk);
    evtIn = '0;
  endtask

  // {write code, expected stored code, event, expected data}
  localparam logic [42:0] TBL [7] = '{
    {3'd0, 3'd0, 5'd3,  32'h0000C14F},
    {3'd1, 3'd1, 5'd2,  32'h0000C14E},
    {3'd2, 3'd2, 5'd6,  32'h0000C14E},
    {3'd3, 3'd3, 5'd9,  32'h0000C149},
    {3'd5, 3'd3, 5'd15, 32'h0000C14F},
    {3'd7, 3'd3, 5'd20, 32'h0000C14C},
    {3'd3, 3'd3, 5'd0,  32'h0000C148}
  };
  localparam logic [63:0] EXP_ADDR = 64'h12345678_FEEA5008;

  bit finished = 1'b0;

  initial begin
    #(200000 * 10);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog actual=%h expected=%h", 0, 1);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    logic [31:0] hold;
    int base;
    cyc(3);
    rstN = 1'b1;
    cyc(1);

    // R1 reset state
    check(wrValid == 1'b0, "R1 wrValid", 64'(wrValid), 64'd0);
    regRead(2'd0, rd); check(rd == 32'h86, "R1 control", 64'(rd), 64'h86);
    regRead(2'd1, rd); check(rd == 32'hFEE00000, "R1 addr low", 64'(rd), 64'hFEE00000);
    regRead(2'd3, rd); check(rd == 32'h0, "R1 data", 64'(rd), 64'h0);

    // R2 and R3: read-only and reserved control bits, clamp of reserved code
    regWrite(2'd0, 32'hFFFF_FFFE);
    regRead(2'd0, rd); check(rd == 32'hB6, "R2 R3 control all ones", 64'(rd), 64'hB6);
    regWrite(2'd0, 32'h0);
    regRead(2'd0, rd); check(rd == 32'h86, "R2 control cleared", 64'(rd), 64'h86);

    // R4 address fields
    regWrite(2'd1, 32'hFFFF_FFFF);
    regRead(2'd1, rd); check(rd == 32'hFEEFF00C, "R4 addr low ones", 64'(rd), 64'hFEEFF00C);
    regWrite(2'd2, 32'h12345678);
    regRead(2'd2, rd); check(rd == 32'h12345678, "R4 addr high", 64'(rd), 64'h12345678);
    regWrite(2'd1, 32'h000A5008);

    // R5 data fields
    regWrite(2'd3, 32'hFFFF_FFFF);
    regRead(2'd3, rd); check(rd == 32'h0000C7FF, "R5 data ones", 64'(rd), 64'hC7FF);
    regWrite(2'd3, 32'h0000C14F);

    // R6 and R9: held while disabled, then lowest index first
    base = nGot;
    pulse(5); pulse(2);
    cyc(10);
    check(nGot == base, "R6 no write while disabled", 64'(nGot - base), 64'd0);
    regWrite(2'd0, 32'h31);
    cyc(12);
    check(nGot == base + 2, "R9 one write per event", 64'(nGot - base), 64'd2);
    check(gotData[base] == 32'h0000C14A, "R9 first event 2", 64'(gotData[base]), 64'hC14A);
    check(gotData[base+1] == 32'h0000C14D, "R9 second event 5", 64'(gotData[base+1]), 64'hC14D);
    check(gotAddr[base] == EXP_ADDR, "R7 address", gotAddr[base], EXP_ADDR);

    // R3 R8 table walk
    for (int i = 0; i < 7; i++) begin
      logic [2:0] wc, ec;
      logic [4:0] ev;
      logic [31:0] ed;
      {wc, ec, ev, ed} = TBL[i];
      regWrite(2'd0, {25'd0, wc, 4'b0001});
      regRead(2'd0, rd);
      check(rd[6:4] == ec, "R3 granted code", 64'(rd[6:4]), 64'(ec));
      base = nGot;
      pulse(int'(ev));
      cyc(6);
      check(nGot == base + 1, "R9 single write", 64'(nGot - base), 64'd1);
      check(gotData[base] == ed, "R8 low vector bits", 64'(gotData[base]), 64'(ed));
      check(gotAddr[base] == EXP_ADDR, "R7 address", gotAddr[base], EXP_ADDR);
    end

    // R10 hold under back-pressure (granted code 3 still set)
    wrReady = 1'b0;
    base = nGot;
    pulse(1);
    cyc(4);
    check(wrValid == 1'b1, "R10 valid raised", 64'(wrValid), 64'd1);
    hold = wrData;
    cyc(3);
    check(wrValid == 1'b1 && wrData == hold, "R10 held stable", 64'(wrData), 64'(hold));
    check(nGot == base, "R10 nothing accepted", 64'(nGot - base), 64'd0);

    // R11 event on its own acceptance cycle re-arms
    @(negedge clk);
    wrReady = 1'b1; evtIn = '0; evtIn[1] = 1'b1;
    @(negedge clk);
    evtIn = '0;
    cyc(8);
    check(nGot == base + 2, "R11 second write", 64'(nGot - base), 64'd2);
    check(gotData[base+1] == 32'h0000C149, "R11 data", 64'(gotData[base+1]), 64'hC149);
    check(wrValid == 1'b0, "R9 idle after drain", 64'(wrValid), 64'd0);

    finished = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule